// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures a signal in one of two ways with a single binary counter. In frequency mode it counts rising edges of the chosen input during a fixed gate window timed from the reference clock. In period mode it counts reference clock cycles across one or two whole periods of the input. There are two measured inputs, a fast one and a slow one. Period mode is only available on the slow input. Selecting the fast input always gives frequency mode, whatever the mode bit says.

Both measured inputs are asynchronous. Each one passes through a two-flop synchroniser before its edges are detected. A rising edge on the start pin does three things: it clears the count, it samples the control pins, and it starts the measurement. When the window closes, the done flag rises and the count freezes. Both stay that way until the next start. The count is a plain level output and has no handshake. Software-side readout logic should sample it while done is high.

With the default 7.2 MHz reference, the gate lengths of 86,400 and 172,800 cycles give windows of 12 ms and 24 ms.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, count is 0 and done is 0.
- R2: A low-to-high change on start clears count to 0 and drops done in the next cycle and begins a new measurement, even if one is in progress. A start pin held high or falling has no effect.
- R3: The count saturates at all-ones (2^CNT_W-1) and never wraps.
- R4: In frequency mode with gate_long=0, the final count equals the number of rising edges of the selected input within GATE_SHORT reference cycles.
- R5: In frequency mode with gate_long=1, the window is GATE_LONG reference cycles.
- R6: With sel_lf=1 and mode_period=1 and gate_long=0, the final count equals the number of reference cycles in one period of lf_in, measured between consecutive rising edges.
- R7: With sel_lf=1, mode_period=1 and gate_long=1, the final count covers two whole periods of lf_in.
- R8: With sel_lf=0, mode_period is ignored and frequency mode is used.
- R9: sel_lf=1 measures lf_in and sel_lf=0 measures hf_in.
- R10: done rises when the window closes. While done is high and no new start occurs, done stays high and count holds its value.
- R11: sel_lf, mode_period and gate_long are sampled only at the start edge. Changing them during a measurement does not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the timebase for gate and period counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_in | input | 1 | Fast measured input, asynchronous |
| lf_in | input | 1 | Slow measured input, asynchronous |
| sel_lf | input | 1 | 1 selects lf_in, 0 selects hf_in |
| mode_period | input | 1 | 1 asks for period mode (honoured only when sel_lf=1) |
| gate_long | input | 1 | Frequency: long gate; period: two periods instead of one |
| start | input | 1 | Rising edge clears and starts a measurement |
| count | output | CNT_W | Measurement counter, final when done is high |
| done | output | 1 | High from window close until the next start |

## Verification
The assertions assume the following about the inputs:
- Each high and low phase of a measured input lasts at least one reference cycle, so the synchroniser never merges two edges.
- The start pin stays in each state for at least one cycle.
- Both gate lengths are at least one cycle.

The bench keeps within these assumptions. It changes every input on the falling clock edge, uses input periods of two cycles or more, and holds start high for two cycles or longer. It shortens the gate lengths and narrows the counter through parameters, so that saturation and both window lengths can be reached in a short run.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GATE   = 3'd1,
    ST_ARM    = 3'd2,
    ST_PERIOD = 3'd3,
    ST_DONE   = 3'd4
  } meas_state_e;

  typedef struct packed {
    logic use_lf;
    logic long_win;
  } meas_cfg_t;

endpackage

// File: rtl/gcm_edge_sync.sv
module gcm_edge_sync #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] rise
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        s3 <= s2;
      end
    end

    assign rise[i] = s2 & ~s3;

    // a detected edge lasts exactly one cycle, so each edge is counted once (R4)
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end

endmodule

// File: rtl/gcm_gate_timer.sv
module gcm_gate_timer #(
  parameter int GATE_SHORT = 86400,
  parameter int GATE_LONG  = 172800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic long_win,
  output logic expire
);

  localparam int MAX_GATE = (GATE_LONG > GATE_SHORT) ? GATE_LONG : GATE_SHORT;
  localparam int TMR_W    = $clog2(MAX_GATE + 1);
  localparam logic [TMR_W-1:0] LIM_S = TMR_W'(GATE_SHORT - 1);
  localparam logic [TMR_W-1:0] LIM_L = TMR_W'(GATE_LONG - 1);
  localparam logic [TMR_W-1:0] LIM_M = TMR_W'(MAX_GATE - 1);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] limit_m1;

  assign limit_m1 = long_win ? LIM_L : LIM_S;
  assign expire   = run && (tmr == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr <= '0;
    else if (clear)            tmr <= '0;
    else if (run && !expire)   tmr <= tmr + 1'b1;
  end

  // the timer never runs past the longest window (R5)
  p_tmr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= LIM_M);

  // a clear always restarts the window from zero (R4)
  p_tmr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> tmr == '0);

endmodule

// File: rtl/gcm_sat_counter.sv
module gcm_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          value <= '0;
    else if (clear)                      value <= '0;
    else if (inc && value != ALL_ONES)   value <= value + 1'b1;
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (value == ALL_ONES && !clear) |=> value == ALL_ONES);

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> value >= $past(value));

endmodule

// File: rtl/gcm_meas_ctrl.sv
module gcm_meas_ctrl
  import gcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_lf,
  input  logic mode_period,
  input  logic gate_long,
  input  logic hf_rise,
  input  logic lf_rise,
  input  logic tmr_expire,
  output logic cnt_clear,
  output logic cnt_inc,
  output logic tmr_clear,
  output logic tmr_run,
  output logic tmr_long,
  output logic done
);

  meas_state_e state;
  meas_cfg_t   cfg;
  logic        start_q;
  logic        start_rise;
  logic        per_seen;
  logic        sel_rise;
  logic        want_period;

  assign start_rise  = start & ~start_q;
  assign sel_rise    = cfg.use_lf ? lf_rise : hf_rise;
  assign want_period = sel_lf & mode_period;
  assign tmr_long    = cfg.long_win;
  assign done        = (state == ST_DONE);

  always_comb begin
    cnt_clear = start_rise;
    tmr_clear = start_rise;
    cnt_inc   = 1'b0;
    tmr_run   = 1'b0;
    if (!start_rise) begin
      case (state)
        ST_GATE: begin
          cnt_inc = sel_rise;
          tmr_run = 1'b1;
        end
        ST_PERIOD: cnt_inc = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      state    <= ST_IDLE;
      cfg      <= '0;
      per_seen <= 1'b0;
    end else begin
      start_q <= start;
      if (start_rise) begin
        cfg.use_lf   <= sel_lf;
        cfg.long_win <= gate_long;
        per_seen     <= 1'b0;
        state        <= want_period ? ST_ARM : ST_GATE;
      end else begin
        case (state)
          ST_GATE:   if (tmr_expire) state <= ST_DONE;
          ST_ARM:    if (sel_rise)   state <= ST_PERIOD;
          ST_PERIOD: if (sel_rise) begin
            if (per_seen == cfg.long_win) state    <= ST_DONE;
            else                          per_seen <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> !done);

  p_hf_freq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !sel_lf) |=> state == ST_GATE);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_rise) |=> done);

  p_cfg_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_rise |=> $stable(cfg));

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int CNT_W      = 20,
  parameter int GATE_SHORT = 86400,
  parameter int GATE_LONG  = 172800
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             hf_in,
  input  logic             lf_in,
  input  logic             sel_lf,
  input  logic             mode_period,
  input  logic             gate_long,
  input  logic             start,
  output logic [CNT_W-1:0] count,
  output logic             done
);

  localparam int LANES = 2;
  localparam int LANE_HF = 0;
  localparam int LANE_LF = 1;

  logic [LANES-1:0] raw_in;
  logic [LANES-1:0] rise;
  logic cnt_clear, cnt_inc, tmr_clear, tmr_run, tmr_long, tmr_expire;

  assign raw_in[LANE_HF] = hf_in;
  assign raw_in[LANE_LF] = lf_in;

  gcm_edge_sync #(.LANES(LANES)) sync_i (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .raw   (raw_in),
    .rise  (rise)
  );

  gcm_meas_ctrl ctrl_i (
    .clk         (clk_ref),
    .rst_n       (rst_n),
    .start       (start),
    .sel_lf      (sel_lf),
    .mode_period (mode_period),
    .gate_long   (gate_long),
    .hf_rise     (rise[LANE_HF]),
    .lf_rise     (rise[LANE_LF]),
    .tmr_expire  (tmr_expire),
    .cnt_clear   (cnt_clear),
    .cnt_inc     (cnt_inc),
    .tmr_clear   (tmr_clear),
    .tmr_run     (tmr_run),
    .tmr_long    (tmr_long),
    .done        (done)
  );

  gcm_gate_timer #(.GATE_SHORT(GATE_SHORT), .GATE_LONG(GATE_LONG)) timer_i (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .clear    (tmr_clear),
    .run      (tmr_run),
    .long_win (tmr_long),
    .expire   (tmr_expire)
  );

  gcm_sat_counter #(.W(CNT_W)) counter_i (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .inc   (cnt_inc),
    .value (count)
  );

  // the count is frozen while the result is presented (R10)
  p_count_frozen_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (done && !cnt_clear) |=> $stable(count));

endmodule

// File: tb/gated_freq_counter_tb_top.sv
module gated_freq_counter_tb_top;

  localparam int CNT_W = 8;
  localparam int GS    = 48;
  localparam int GL    = 96;

  typedef struct packed {
    logic        s;
    logic        m;
    logic        g;
    logic [7:0]  hp;
    logic [7:0]  lp;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 1'b0, 1'b0, 8'd4,  8'd6,   16'd12},  // R4 R9 hf 48/4
    '{1'b0, 1'b0, 1'b1, 8'd4,  8'd6,   16'd24},  // R5 hf 96/4
    '{1'b1, 1'b0, 1'b0, 8'd4,  8'd6,   16'd8},   // R9 lf 48/6
    '{1'b1, 1'b0, 1'b1, 8'd8,  8'd6,   16'd16},  // R5 lf 96/6
    '{1'b0, 1'b1, 1'b0, 8'd4,  8'd6,   16'd12},  // R8 mode ignored
    '{1'b0, 1'b1, 1'b1, 8'd8,  8'd6,   16'd12},  // R8 96/8
    '{1'b1, 1'b1, 1'b0, 8'd4,  8'd6,   16'd6},   // R6 one period
    '{1'b1, 1'b1, 1'b1, 8'd4,  8'd10,  16'd20},  // R7 two periods
    '{1'b1, 1'b1, 1'b0, 8'd4,  8'd16,  16'd16},  // R6
    '{1'b1, 1'b1, 1'b1, 8'd4,  8'd150, 16'd255}, // R3 saturation
    '{1'b0, 1'b0, 1'b1, 8'd2,  8'd3,   16'd48}   // R5 fastest input
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hf_in = 1'b0, lf_in = 1'b0;
  logic sel_lf = 1'b0, mode_period = 1'b0, gate_long = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] count;
  logic done;

  int checks = 0;
  int failures = 0;
  int hp = 4, lp = 6, hph = 0, lph = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    hph = (hph + 1 >= hp) ? 0 : hph + 1;
    lph = (lph + 1 >= lp) ? 0 : lph + 1;
    hf_in <= (hph < hp / 2);
    lf_in <= (lph < lp / 2);
  end

  gated_freq_counter #(.CNT_W(CNT_W), .GATE_SHORT(GS), .GATE_LONG(GL)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .hf_in(hf_in), .lf_in(lf_in),
    .sel_lf(sel_lf), .mode_period(mode_period), .gate_long(gate_long),
    .start(start), .count(count), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    int n;
    n = 2 * ((hp > lp) ? hp : lp) + 8;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done, req, "done timeout", int'(done), 1);
  endtask

  task automatic measure(input logic s, input logic m, input logic g,
                         input int exp, input string req);
    @(negedge clk);
    sel_lf = s; mode_period = m; gate_long = g; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
    chk(int'(count) == exp, req, "count", int'(count), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string req;
    int held;
    repeat (4) @(negedge clk);
    chk(count == '0 && !done, "R1", "during reset", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == '0, "R1", "count after reset", int'(count), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      hp = int'(VECS[i].hp);
      lp = int'(VECS[i].lp);
      settle();
      if (VECS[i].exp == 16'd255) req = "R3";
      else if (VECS[i].s) req = VECS[i].m ? (VECS[i].g ? "R7" : "R6") : "R9";
      else req = VECS[i].m ? "R8" : (VECS[i].g ? "R5" : "R4");
      measure(VECS[i].s, VECS[i].m, VECS[i].g, int'(VECS[i].exp), req);
    end

    // R10: result holds while no new start
    held = int'(count);
    repeat (25) @(negedge clk);
    chk(done, "R10", "done holds", int'(done), 1);
    chk(int'(count) == held, "R10", "count holds", int'(count), held);

    // R2: start held high does not restart; fall has no effect
    hp = 4; lp = 6;
    settle();
    @(negedge clk);
    sel_lf = 0; mode_period = 0; gate_long = 0; start = 1'b1;
    @(negedge clk);
    chk(!done && count == '0, "R2", "clear on start edge", int'(count), 0);
    wait_done("R2");
    held = int'(count);
    repeat (30) @(negedge clk);
    chk(done && int'(count) == held, "R2", "held start no restart", int'(count), held);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(done && int'(count) == held, "R2", "falling start no effect", int'(count), held);

    // R11: control changes during measurement are ignored
    @(negedge clk);
    sel_lf = 0; mode_period = 0; gate_long = 0; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0; sel_lf = 1; mode_period = 1; gate_long = 1;
    wait_done("R11");
    chk(int'(count) == 12, "R11", "late control change", int'(count), 12);

    // R2: restart in the middle of a long period measurement
    lp = 150;
    settle();
    @(negedge clk);
    sel_lf = 1; mode_period = 1; gate_long = 1; start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    sel_lf = 0; mode_period = 0; gate_long = 0; start = 1'b1;
    @(negedge clk);
    chk(!done && count == '0, "R2", "restart clears", int'(count), 0);
    @(negedge clk);
    start = 1'b0;
    wait_done("R2");
    chk(int'(count) == 12, "R2", "restart result", int'(count), 12);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule